// File: doc/BRIEF.md
# Masked Time Alarm Comparator

This block keeps two programmable alarms and tests them against the current calendar time, which arrives in BCD, once each second. The first alarm holds seconds, minutes, hours and a day/date value. The second alarm holds minutes, hours and a day/date value, and it can only fire when the seconds count is 00. Each alarm register carries a mask bit. A masked field takes no part in the compare, so one alarm can repeat each second, each minute, each hour, each day or once a month. When an alarm matches, it sets its own sticky flag. Software can clear a flag, but it can never set one.

A single active-low output is shared between two uses. In interrupt mode it goes low while any enabled flag is set. In wave mode it carries a square wave, and two rate bits pick which of four toggle strobes drives it. The timekeeping counters and the bus interface sit outside this block. A parent drives the time fields, a one-cycle per-second strobe, a byte write port and the four toggle strobes.

A small state machine drives the output. It has four states: `ST_IRQ_IDLE` (released), `ST_IRQ_ACTIVE` (low), `ST_WAVE_HIGH` (released) and `ST_WAVE_LOW` (low).

Its transitions are:
- From either interrupt state, a clear mode bit moves it to `ST_WAVE_HIGH`. Otherwise it goes to `ST_IRQ_ACTIVE` when an enabled flag is set, and to `ST_IRQ_IDLE` when none is.
- From either wave state, a set mode bit returns it to the interrupt states by the same rule.
- In wave mode, the selected toggle strobe swaps `ST_WAVE_HIGH` and `ST_WAVE_LOW`, and it holds its state otherwise.

Top module: `almcmp_top`

## Requirements
- R1: After reset, `alarm_n` is 1 (released), both flags are 0, the output is in interrupt mode and both interrupt enables are 0. The rate bits reset to 11.
- R2: The write port holds the first alarm at addresses 0 (seconds), 1 (minutes), 2 (hours) and 3 (day/date). Bit 7 of each is a mask, and 1 leaves that field out of the compare. Fields are compared on bits 6:0 (day/date on bits 5:0). With all four masks set, the first alarm fires on every strobe.
- R3: The second alarm sits at addresses 4 (minutes), 5 (hours) and 6 (day/date), laid out the same way as the first. It has no seconds field and fires only on a strobe where `now_sec` is 00. With all three masks set, it fires once per minute.
- R4: Bit 6 of a day/date register selects the compare. A 1 compares bits 5:0 with `now_wday`, and a 0 compares them with `now_mday`.
- R5: The hour compare covers all of bits 6:0, so the 12/24 mode bit (bit 6) and the AM/PM or twenty-hour bit (bit 5) must match as well.
- R6: Matches are tested only on a cycle with `sec_tick` high. Flag n (bit n of `alarm_flags`, bit 0 for the first alarm) rises on the edge that samples the strobe. It rises whether or not its interrupt is enabled.
- R7: A write to address 8 clears each flag whose data bit (bit 0 or bit 1) is 0. A data bit of 1 leaves its flag unchanged. A match in the same cycle wins over a clear.
- R8: The control register sits at address 7. Bits 1:0 are the interrupt enables, bit 2 is the mode bit (1 selects interrupt), and bits 4:3 are the rate. In interrupt mode, `alarm_n` goes low one edge after a flag with its enable set is seen, and it is released one edge after no such flag remains.
- R9: With the mode bit at 0, `alarm_n` starts released and toggles on each cycle where `wave_tick[rate]` is high. Rate 00 selects bit 0 (1 Hz), 01 selects bit 1 (1.024 kHz), 10 selects bit 2 (4.096 kHz) and 11 selects bit 3 (8.192 kHz). The other strobe bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sec_tick | input | 1 | One-cycle strobe at each time update |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 7 | Current hours with mode and AM/PM bits |
| now_wday | input | 6 | Current day of week |
| now_mday | input | 6 | Current date of month, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| wave_tick | input | 4 | Toggle strobes for the four wave rates |
| alarm_flags | output | 2 | Sticky alarm flags, bit 0 for the first alarm |
| alarm_n | output | 1 | Shared interrupt/square-wave output, 1 = released |

## Verification
There are three result latencies to track:
- A strobe, or a write to the flag address, driven before an edge changes `alarm_flags` right after that edge.
- In interrupt mode, `alarm_n` follows one edge later, two edges after the stimulus.
- In wave mode, a selected toggle strobe flips `alarm_n` right after the edge that samples it.

Every stimulus task places its expected items in the scoreboard, each stamped with the cycle number when it falls due. The monitor compares each item a quarter period after that edge. This way each check lands on exactly the cycle the register count predicts.

// File: rtl/almcmp_pkg.sv
package almcmp_pkg;
    localparam int FIELD_W    = 8;
    localparam int N_ALARMS   = 2;
    localparam int N_ALM_REGS = 7;
    localparam int ADDR_CTRL  = 7;
    localparam int ADDR_STAT  = 8;
    localparam int MASK_BIT   = 7;
    localparam int DAYSEL_BIT = 6;
    localparam int RATE_W     = 2;
    localparam int N_RATES    = 1 << RATE_W;
    localparam int CB_IE0     = 0;
    localparam int CB_INTCTL  = 2;
    localparam int CB_RATE_LO = 3;

    typedef enum logic [1:0] {
        ST_IRQ_IDLE,
        ST_IRQ_ACTIVE,
        ST_WAVE_HIGH,
        ST_WAVE_LOW
    } pin_state_t;
endpackage

// File: rtl/almcmp_regs.sv
module almcmp_regs
    import almcmp_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [AW-1:0]                        wr_addr,
    input  logic [FIELD_W-1:0]                   wr_data,
    output logic [N_ALM_REGS-1:0][FIELD_W-1:0]   alm_q,
    output logic [N_ALARMS-1:0]                  irq_en,
    output logic                                 intctl,
    output logic [RATE_W-1:0]                    rate_sel
);
    // Control register: enables, mode bit and rate bits.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en   <= '0;
            intctl   <= 1'b1;
            rate_sel <= '1;
        end else if (wr_en && wr_addr == AW'(ADDR_CTRL)) begin
            irq_en   <= wr_data[CB_IE0 +: N_ALARMS];
            intctl   <= wr_data[CB_INTCTL];
            rate_sel <= wr_data[CB_RATE_LO +: RATE_W];
        end
    end

    // One byte register per alarm field.
    for (genvar g = 0; g < N_ALM_REGS; g++) begin : g_alm
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                alm_q[g] <= '0;
            else if (wr_en && wr_addr == AW'(g))
                alm_q[g] <= wr_data;
        end
    end
endmodule

// File: rtl/almcmp_match.sv
module almcmp_match
    import almcmp_pkg::*;
(
    input  logic [FIELD_W-1:0] reg_sec,
    input  logic [FIELD_W-1:0] reg_min,
    input  logic [FIELD_W-1:0] reg_hour,
    input  logic [FIELD_W-1:0] reg_dd,
    input  logic [6:0]         now_sec,
    input  logic [6:0]         now_min,
    input  logic [6:0]         now_hour,
    input  logic [5:0]         now_wday,
    input  logic [5:0]         now_mday,
    output logic               hit
);
    logic sec_ok, min_ok, hour_ok, dd_ok;
    logic [5:0] dd_now;

    always_comb begin
        dd_now  = reg_dd[DAYSEL_BIT] ? now_wday : now_mday;
        sec_ok  = reg_sec[MASK_BIT]  | (reg_sec[6:0]  == now_sec);
        min_ok  = reg_min[MASK_BIT]  | (reg_min[6:0]  == now_min);
        hour_ok = reg_hour[MASK_BIT] | (reg_hour[6:0] == now_hour);
        dd_ok   = reg_dd[MASK_BIT]   | (reg_dd[5:0]   == dd_now);
        hit     = sec_ok & min_ok & hour_ok & dd_ok;
    end
endmodule

// File: rtl/almcmp_flags.sv
module almcmp_flags
    import almcmp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sec_tick,
    input  logic [N_ALARMS-1:0] hit,
    input  logic                clr_wr,
    input  logic [N_ALARMS-1:0] clr_keep,
    output logic [N_ALARMS-1:0] flags
);
    for (genvar g = 0; g < N_ALARMS; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flags[g] <= 1'b0;
            else if (sec_tick && hit[g])
                flags[g] <= 1'b1;
            else if (clr_wr && !clr_keep[g])
                flags[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/almcmp_pin.sv
module almcmp_pin
    import almcmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_req,
    input  logic intctl,
    input  logic wave_step,
    output logic pin_n
);
    pin_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IRQ_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IRQ_IDLE, ST_IRQ_ACTIVE: begin
                if (!intctl)     state_nx = ST_WAVE_HIGH;
                else if (irq_req) state_nx = ST_IRQ_ACTIVE;
                else             state_nx = ST_IRQ_IDLE;
            end
            ST_WAVE_HIGH: begin
                if (intctl)         state_nx = irq_req ? ST_IRQ_ACTIVE : ST_IRQ_IDLE;
                else if (wave_step) state_nx = ST_WAVE_LOW;
            end
            ST_WAVE_LOW: begin
                if (intctl)         state_nx = irq_req ? ST_IRQ_ACTIVE : ST_IRQ_IDLE;
                else if (wave_step) state_nx = ST_WAVE_HIGH;
            end
            default: state_nx = ST_IRQ_IDLE;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_IRQ_ACTIVE, ST_WAVE_LOW: pin_n = 1'b0;
            default:                    pin_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/almcmp_top.sv
module almcmp_top
    import almcmp_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sec_tick,
    input  logic [6:0]          now_sec,
    input  logic [6:0]          now_min,
    input  logic [6:0]          now_hour,
    input  logic [5:0]          now_wday,
    input  logic [5:0]          now_mday,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [7:0]          wr_data,
    input  logic [N_RATES-1:0]  wave_tick,
    output logic [N_ALARMS-1:0] alarm_flags,
    output logic                alarm_n
);
    logic [N_ALM_REGS-1:0][FIELD_W-1:0] alm_q;
    logic [N_ALARMS-1:0]                irq_en;
    logic                               intctl;
    logic [RATE_W-1:0]                  rate_sel;
    logic [N_ALARMS-1:0]                hit;
    logic                               irq_req;
    logic                               wave_step;

    almcmp_regs #(.AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .alm_q    (alm_q),
        .irq_en   (irq_en),
        .intctl   (intctl),
        .rate_sel (rate_sel)
    );

    // Alarm 0 owns a seconds register; later alarms compare against 00.
    for (genvar g = 0; g < N_ALARMS; g++) begin : g_cmp
        localparam int BASE = (g == 0) ? 0 : 3;
        logic [FIELD_W-1:0] sec_reg;
        if (g == 0) begin : g_sec
            assign sec_reg = alm_q[BASE];
        end else begin : g_nosec
            assign sec_reg = '0;
        end
        almcmp_match u_match (
            .reg_sec  (sec_reg),
            .reg_min  (alm_q[BASE+1]),
            .reg_hour (alm_q[BASE+2]),
            .reg_dd   (alm_q[BASE+3]),
            .now_sec  (now_sec),
            .now_min  (now_min),
            .now_hour (now_hour),
            .now_wday (now_wday),
            .now_mday (now_mday),
            .hit      (hit[g])
        );
    end

    almcmp_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .hit      (hit),
        .clr_wr   (wr_en && wr_addr == AW'(ADDR_STAT)),
        .clr_keep (wr_data[N_ALARMS-1:0]),
        .flags    (alarm_flags)
    );

    assign irq_req   = |(alarm_flags & irq_en);
    assign wave_step = wave_tick[rate_sel];

    almcmp_pin u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req   (irq_req),
        .intctl    (intctl),
        .wave_step (wave_step),
        .pin_n     (alarm_n)
    );
endmodule

// File: rtl/almcmp_chk.sv
module almcmp_chk
    import almcmp_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                sec_tick,
    input logic                wr_en,
    input logic [3:0]          wr_addr,
    input logic [7:0]          wr_data,
    input logic [N_RATES-1:0]  wave_tick,
    input logic [N_ALARMS-1:0] alarm_flags,
    input logic                alarm_n,
    input logic [N_ALARMS-1:0] irq_en,
    input logic                intctl,
    input logic [RATE_W-1:0]   rate_sel
);
    AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (alarm_n && alarm_flags == 2'b00)); // R1

    AST_FLAG_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> ((alarm_flags & ~$past(alarm_flags)) == 2'b00)); // R6

    AST_ONE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 4'(ADDR_STAT) && wr_data[1:0] == 2'b11)
        |=> (($past(alarm_flags) & ~alarm_flags) == 2'b00)); // R7

    AST_ZERO_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 4'(ADDR_STAT) && !sec_tick)
        |=> ((alarm_flags & ~$past(wr_data[1:0])) == 2'b00)); // R7

    AST_PIN_LOW_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        intctl |=> (alarm_n || $past((alarm_flags & irq_en) != 2'b00))); // R8

    AST_WAVE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!intctl && !$past(intctl)) |=> (alarm_n == $past(alarm_n) || $past(wave_tick[rate_sel]))); // R9
endmodule

bind almcmp_top almcmp_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sec_tick    (sec_tick),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .wave_tick   (wave_tick),
    .alarm_flags (alarm_flags),
    .alarm_n     (alarm_n),
    .irq_en      (irq_en),
    .intctl      (intctl),
    .rate_sel    (rate_sel)
);

// File: tb/sim_almcmp_top.sv
module sim_almcmp_top;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic [6:0] now_sec = '0, now_min = '0, now_hour = '0;
    logic [5:0] now_wday = '0, now_mday = '0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] wave_tick = '0;
    logic [1:0] alarm_flags;
    logic       alarm_n;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int         due;
        int         kind;   // 0: flags, 1: pin
        logic [1:0] val;
        string      tag;
    } exp_t;
    exp_t sb[$];

    almcmp_top u0 (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
        .now_wday(now_wday), .now_mday(now_mday),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wave_tick(wave_tick), .alarm_flags(alarm_flags), .alarm_n(alarm_n)
    );

    always #(PERIOD/2) clk = ~clk;

    // Monitor: pops every item due at this edge and compares.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #(PERIOD/4);
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                exp_t it;
                logic [1:0] act;
                it  = sb.pop_front();
                act = (it.kind == 0) ? alarm_flags : {1'b0, alarm_n};
                checks++;
                if (act !== it.val) begin
                    errors++;
                    $display("FAIL %s (%s): actual %b expected %b at cycle %0d",
                             it.tag, (it.kind == 0) ? "flags" : "pin", act, it.val, cyc);
                end
            end
        end
    end

    task automatic push(input int d, input int k, input logic [1:0] v, input string t);
        sb.push_back('{cyc + d, k, v, t});
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wrc(input logic [3:0] a, input logic [7:0] d,
                       input logic [1:0] ef, input logic eo, input string t);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        push(1, 0, ef, t);
        push(2, 1, {1'b0, eo}, t);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step(input logic [6:0] s, input logic [6:0] m, input logic [6:0] h,
                        input logic [5:0] wd, input logic [5:0] md,
                        input logic [1:0] ef, input logic eo, input string t);
        @(negedge clk);
        now_sec = s; now_min = m; now_hour = h; now_wday = wd; now_mday = md;
        sec_tick = 1'b1;
        push(1, 0, ef, t);
        push(2, 1, {1'b0, eo}, t);
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic tickp(input int idx, input logic eo, input string t);
        @(negedge clk);
        wave_tick[idx] = 1'b1;
        push(1, 1, {1'b0, eo}, t);
        @(negedge clk);
        wave_tick = '0;
    endtask

    initial begin
        #(PERIOD * 50000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        push(1, 0, 2'b00, "R1 reset flags");
        push(1, 1, 2'b01, "R1 reset pin");
        wr(4'd7, 8'h07);
        wr(4'd0, 8'h80); wr(4'd1, 8'h80); wr(4'd2, 8'h80); wr(4'd3, 8'h80);
        wr(4'd4, 8'h59); wr(4'd5, 8'h23); wr(4'd6, 8'h31);

        // R2 every second, R8 pin low
        step(7'h56, 7'h34, 7'h12, 6'd3, 6'h15, 2'b01, 1'b0, "R2 R8 all masked fires");
        wrc(4'd8, 8'h03, 2'b01, 1'b0, "R7 write ones keeps");
        wrc(4'd8, 8'h02, 2'b00, 1'b1, "R7 R8 clear releases");

        // R2 seconds only
        wr(4'd0, 8'h30);
        step(7'h29, 7'h34, 7'h12, 6'd3, 6'h15, 2'b00, 1'b1, "R2 seconds mismatch");
        step(7'h30, 7'h34, 7'h12, 6'd3, 6'h15, 2'b01, 1'b0, "R2 seconds match");
        wrc(4'd8, 8'h02, 2'b00, 1'b1, "R7 clear");

        // R6 matching time without strobe
        @(negedge clk);
        push(4, 0, 2'b00, "R6 no strobe no flag");
        repeat (4) @(negedge clk);

        // R6 flag without enable
        wr(4'd7, 8'h04);
        step(7'h30, 7'h34, 7'h12, 6'd3, 6'h15, 2'b01, 1'b1, "R6 flag with enable off");
        wrc(4'd8, 8'h02, 2'b00, 1'b1, "R7 clear");
        wr(4'd7, 8'h07);

        // R2 minutes and seconds
        wr(4'd1, 8'h34);
        step(7'h30, 7'h35, 7'h12, 6'd3, 6'h15, 2'b00, 1'b1, "R2 minute mismatch");
        step(7'h30, 7'h34, 7'h12, 6'd3, 6'h15, 2'b01, 1'b0, "R2 minute match");
        wrc(4'd8, 8'h02, 2'b00, 1'b1, "R7 clear");

        // R5 hours incl. mode bits
        wr(4'd2, 8'h12);
        step(7'h30, 7'h34, 7'h12, 6'd3, 6'h15, 2'b01, 1'b0, "R5 hour match");
        wrc(4'd8, 8'h02, 2'b00, 1'b1, "R7 clear");
        step(7'h30, 7'h34, 7'h52, 6'd3, 6'h15, 2'b00, 1'b1, "R5 mode bit differs");

        // R4 date / day select
        wr(4'd3, 8'h15);
        step(7'h30, 7'h34, 7'h12, 6'd3, 6'h15, 2'b01, 1'b0, "R4 date match");
        wrc(4'd8, 8'h02, 2'b00, 1'b1, "R7 clear");
        step(7'h30, 7'h34, 7'h12, 6'd3, 6'h16, 2'b00, 1'b1, "R4 date mismatch");
        wr(4'd3, 8'h43);
        step(7'h30, 7'h34, 7'h12, 6'd3, 6'h16, 2'b01, 1'b0, "R4 weekday match");
        wrc(4'd8, 8'h02, 2'b00, 1'b1, "R7 clear");
        step(7'h30, 7'h34, 7'h12, 6'd4, 6'h03, 2'b00, 1'b1, "R4 weekday select ignores date");

        // R3 second alarm
        wr(4'd0, 8'h59);
        wr(4'd4, 8'h80); wr(4'd5, 8'h80); wr(4'd6, 8'h80);
        step(7'h01, 7'h34, 7'h12, 6'd3, 6'h15, 2'b00, 1'b1, "R3 not at second 00");
        step(7'h00, 7'h34, 7'h12, 6'd3, 6'h15, 2'b10, 1'b0, "R3 once per minute");
        wrc(4'd8, 8'h01, 2'b00, 1'b1, "R7 clear second flag");
        wr(4'd4, 8'h34);
        step(7'h00, 7'h33, 7'h12, 6'd3, 6'h15, 2'b00, 1'b1, "R3 minute mismatch");
        step(7'h05, 7'h34, 7'h12, 6'd3, 6'h15, 2'b00, 1'b1, "R3 minute match off second 00");

        // R7 set beats clear in the same cycle
        @(negedge clk);
        now_sec = 7'h00; now_min = 7'h34; sec_tick = 1'b1;
        wr_en = 1'b1; wr_addr = 4'd8; wr_data = 8'h00;
        push(1, 0, 2'b10, "R7 match wins over clear");
        push(2, 1, 2'b00, "R7 R8 pin after race");
        @(negedge clk);
        sec_tick = 1'b0; wr_en = 1'b0;
        wrc(4'd8, 8'h00, 2'b00, 1'b1, "R7 clear all");

        // R9 square wave
        wrc(4'd7, 8'h08, 2'b00, 1'b1, "R9 wave starts released");
        tickp(1, 1'b0, "R9 rate 01 toggles low");
        tickp(0, 1'b0, "R9 unselected strobe ignored");
        tickp(1, 1'b1, "R9 rate 01 toggles high");
        wr(4'd7, 8'h00);
        tickp(1, 1'b1, "R9 rate 00 ignores bit 1");
        tickp(0, 1'b0, "R9 rate 00 toggles");
        wr(4'd7, 8'h18);
        tickp(3, 1'b1, "R9 rate 11 toggles");
        tickp(2, 1'b1, "R9 rate 11 ignores bit 2");

        repeat (4) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule